// File: doc/BRIEF.md
# Byte-Serial Packet Device Register Interface

This block is the host-facing register slave of a simple packet network device. A host CPU reaches it over a 32-bit register bus with separate read and write strobes. Frame data passes one byte per access through two data ports, and byte counts that move on their own pace the transfer. Incoming frames arrive on a byte stream and are held in an internal buffer until the host has read them out. Outgoing frames are written by the host into a second buffer and then drained onto a byte stream.

The host programs a transmit length, writes that many bytes, and waits for the transmit-done flag. For receive it waits for the receive-available flag, reads the count, then reads the data port that many times. A level interrupt is raised for transmit done, receive available, and a software-triggered test source. The test source has its own set, read and clear rules.

Top module: `pkt_byte_port`

## Requirements
- R1: Reads return data in the cycle after the read strobe, and offsets 0x00/0x04 return the ID_TEXT string with its first character in bits 7:0 of 0x00 (default "PKTDEV01" gives 0x44544B50 and 0x31305645). Offset 0x18 returns IRQ_LINE. After reset all counts, flags and irq are zero and rx_ready is high.
- R2: When the byte marked rx_last is accepted, offset 0x0C holds the frame length, bit 1 of offset 0x14 is set and irq rises.
- R3: Each read of offset 0x1C returns the next received byte in bits 7:0 (bits 31:8 zero) and lowers the count at 0x0C by one. With a zero count the read returns 0 and the count stays 0.
- R4: While bit 1 of 0x14 is set, rx_ready is low and no byte is taken from the receive stream.
- R5: After the host writes a length N to 0x10 and N bytes to 0x20, only bits 7:0 of each write are used. The device streams those N bytes in order on tx_data, with tx_last on the final byte. Writes to 0x20 beyond N are ignored.
- R6: When the final transmit byte is handed off, 0x10 reads 0 and bit 0 of 0x14 is set.
- R7: Writing 1 to bit 0 or bit 1 of 0x14 clears that flag. A 0 in either position leaves it unchanged.
- R8: Writing a value with bit 31 set to 0x14 raises irq. Bit 31 reads as 1 once, then reads 0, and irq stays high until the value 0 is written to 0x14.
- R9: irq is high exactly when transmit done, receive available or the test source is pending.
- R10: Bit 0 of 0x08 is high from the first accepted byte of a frame until its last byte, and while the transmit length at 0x10 is nonzero. Writes to 0x00, 0x04, 0x08, 0x0C and 0x18 have no effect.
- R11: A received frame longer than DEPTH keeps its first DEPTH bytes and reports a count of DEPTH. A transmit length above DEPTH is clamped to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address within the 0x40 window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_ready | output | 1 | Device can accept a receive byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Marks the final transmit byte |
| tx_ready | input | 1 | Sink accepts the transmit byte |

## Verification
The assertions watch rules that hold on every cycle. They check that the receive count falls by one on each data-port read, that rx_ready is held low while a received frame is pending, and that the transmit fill pointer never passes the programmed length. They also check that the final transmit handoff sets the done flag and clears the length, and that a test write raises irq. The bench scenarios are needed for ordering and content. These cover byte order through both buffers, the identifier layout, the read-once behaviour of the test bit against its sticky interrupt, truncation of oversize frames, and writes that must have no effect.

// File: rtl/pkt_byte_port.sv
module pkt_byte_port #(
  parameter int          DEPTH    = 256,
  parameter logic [31:0] IRQ_LINE = 32'd3,
  parameter logic [63:0] ID_TEXT  = "PKTDEV01"
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  localparam logic [3:0] REG_ID_LO = 4'd0;
  localparam logic [3:0] REG_ID_HI = 4'd1;
  localparam logic [3:0] REG_BUSY  = 4'd2;
  localparam logic [3:0] REG_RXCNT = 4'd3;
  localparam logic [3:0] REG_TXCNT = 4'd4;
  localparam logic [3:0] REG_INTC  = 4'd5;
  localparam logic [3:0] REG_INFO  = 4'd6;
  localparam logic [3:0] REG_RXDAT = 4'd7;
  localparam logic [3:0] REG_TXDAT = 4'd8;

  function automatic logic [63:0] byte_swap(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
    return r;
  endfunction

  localparam logic [63:0] ID_VAL = byte_swap(ID_TEXT);

  logic [7:0] rx_mem [DEPTH];
  logic [7:0] tx_mem [DEPTH];

  logic [CNT_W-1:0] rx_wcnt, rx_count, rx_rptr;
  logic             rx_in_frame, rx_pend;
  logic [CNT_W-1:0] tx_len, tx_wptr, tx_rptr;
  logic             tx_drain, tx_done;
  logic             test_bit, test_irq;

  wire [3:0] ridx = bus_addr[5:2];

  wire rd_intc  = bus_rd && ridx == REG_INTC;
  wire wr_intc  = bus_wr && ridx == REG_INTC;
  wire rd_rxdat = bus_rd && ridx == REG_RXDAT && rx_count != '0;
  wire wr_txcnt = bus_wr && ridx == REG_TXCNT && !tx_drain;
  wire wr_txdat = bus_wr && ridx == REG_TXDAT && !tx_drain && tx_wptr < tx_len;

  wire rx_acc   = rx_valid && rx_ready;
  wire rx_fin   = rx_acc && rx_last;
  wire rx_room  = rx_wcnt < DEPTH_C;
  wire tx_fin   = tx_valid && tx_ready && tx_last;

  assign rx_ready = !rx_pend;
  assign irq      = tx_done | rx_pend | test_irq;
  assign tx_valid = tx_drain;
  assign tx_data  = tx_mem[tx_rptr[PTR_W-1:0]];
  assign tx_last  = tx_drain && (tx_rptr == tx_len - 1'b1);

  wire busy = rx_in_frame | (tx_len != '0);

  always_ff @(posedge clk) begin
    if (rx_acc && rx_room) rx_mem[rx_wcnt[PTR_W-1:0]] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (wr_txdat) tx_mem[tx_wptr[PTR_W-1:0]] <= bus_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wcnt     <= '0;
      rx_in_frame <= 1'b0;
      rx_count    <= '0;
      rx_rptr     <= '0;
    end else begin
      if (rx_fin) begin
        rx_wcnt     <= '0;
        rx_in_frame <= 1'b0;
        rx_count    <= rx_room ? rx_wcnt + 1'b1 : DEPTH_C;
        rx_rptr     <= '0;
      end else begin
        if (rx_acc) begin
          rx_in_frame <= 1'b1;
          if (rx_room) rx_wcnt <= rx_wcnt + 1'b1;
        end
        if (rd_rxdat) begin
          rx_count <= rx_count - 1'b1;
          rx_rptr  <= rx_rptr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_len   <= '0;
      tx_wptr  <= '0;
      tx_rptr  <= '0;
      tx_drain <= 1'b0;
    end else if (tx_drain) begin
      if (tx_valid && tx_ready) begin
        tx_rptr <= tx_rptr + 1'b1;
        if (tx_last) begin
          tx_drain <= 1'b0;
          tx_len   <= '0;
          tx_wptr  <= '0;
        end
      end
    end else if (wr_txcnt) begin
      tx_len  <= (bus_wdata > 32'(DEPTH)) ? DEPTH_C : bus_wdata[CNT_W-1:0];
      tx_wptr <= '0;
    end else if (wr_txdat) begin
      tx_wptr <= tx_wptr + 1'b1;
      if (tx_wptr + 1'b1 == tx_len) begin
        tx_drain <= 1'b1;
        tx_rptr  <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_done  <= 1'b0;
      rx_pend  <= 1'b0;
      test_bit <= 1'b0;
      test_irq <= 1'b0;
    end else begin
      tx_done <= tx_fin | (tx_done & ~(wr_intc & bus_wdata[0]));
      rx_pend <= rx_fin | (rx_pend & ~(wr_intc & bus_wdata[1]));
      if (wr_intc && bus_wdata[31]) begin
        test_bit <= 1'b1;
        test_irq <= 1'b1;
      end else if (wr_intc && bus_wdata == 32'd0) begin
        test_bit <= 1'b0;
        test_irq <= 1'b0;
      end else if (rd_intc) begin
        test_bit <= 1'b0;
      end
    end
  end

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    case (ridx)
      REG_ID_LO: rd_val = ID_VAL[31:0];
      REG_ID_HI: rd_val = ID_VAL[63:32];
      REG_BUSY:  rd_val = {31'd0, busy};
      REG_RXCNT: rd_val = 32'(rx_count);
      REG_TXCNT: rd_val = 32'(tx_len);
      REG_INTC:  rd_val = {test_bit, 29'd0, rx_pend, tx_done};
      REG_INFO:  rd_val = IRQ_LINE;
      REG_RXDAT: rd_val = (rx_count != '0) ? {24'd0, rx_mem[rx_rptr[PTR_W-1:0]]} : 32'd0;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_val : '0;
  end

endmodule

// File: rtl/pkt_byte_port_chk.sv
module pkt_byte_port_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [5:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             rx_valid,
  input logic             rx_last,
  input logic             rx_ready,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             tx_last,
  input logic             irq,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_len,
  input logic [CNT_W-1:0] tx_wptr,
  input logic             rx_pend,
  input logic             tx_done
);

  a_r3_rx_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[5:2] == 4'd7 && rx_count != '0 && !(rx_valid && rx_ready && rx_last))
    |=> rx_count == $past(rx_count) - 1'b1);

  a_r4_rx_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pend |-> !rx_ready);

  a_r5_tx_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wptr <= tx_len);

  a_r6_tx_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> (tx_done && tx_len == '0));

  a_r8_test_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[5:2] == 4'd5 && bus_wdata[31]) |=> irq);

endmodule

bind pkt_byte_port pkt_byte_port_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .rx_valid(rx_valid), .rx_last(rx_last), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last), .irq(irq),
  .rx_count(rx_count), .tx_len(tx_len), .tx_wptr(tx_wptr),
  .rx_pend(rx_pend), .tx_done(tx_done)
);

// File: tb/pkt_byte_port_bench.sv
`timescale 1ns/1ps
module pkt_byte_port_bench;

  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid, tx_last;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;

  int n_run = 0, n_fail = 0;

  logic [7:0] cap [0:15];
  logic       cap_last [0:15];
  int         ncap = 0;

  always #5 clk = ~clk;

  pkt_byte_port #(.DEPTH(DEPTH)) u_pkt_byte_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  always @(negedge clk) begin
    #1;
    if (tx_valid && tx_ready && ncap < 16) begin
      cap[ncap] = tx_data;
      cap_last[ncap] = tx_last;
      ncap++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rx_byte(input logic [7:0] d, input logic last);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_last = last;
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    check("R1 rx_ready after reset", {31'd0, rx_ready}, 32'd1);
    rd(6'h00, v); check("R1 id low", v, 32'h44544B50);
    rd(6'h04, v); check("R1 id high", v, 32'h31305645);
    rd(6'h18, v); check("R1 info", v, 32'd3);
    rd(6'h14, v); check("R1 intc reset", v, 32'd0);
    rd(6'h0C, v); check("R1 rx count reset", v, 32'd0);
    wr(6'h0C, 32'd7); wr(6'h08, 32'd1); wr(6'h18, 32'd9); wr(6'h00, 32'd5);
    rd(6'h0C, v); check("R10 rx count write ignored", v, 32'd0);
    rd(6'h08, v); check("R10 busy write ignored", v, 32'd0);
    rd(6'h18, v); check("R10 info write ignored", v, 32'd3);
    rd(6'h00, v); check("R10 id write ignored", v, 32'h44544B50);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    rx_byte(8'hA0, 1'b0);
    rd(6'h08, v); check("R10 busy mid frame", v, 32'd1);
    for (int i = 1; i < 5; i++) rx_byte(8'hA0 + 8'(i), i == 4);
    rd(6'h08, v); check("R10 busy after frame", v, 32'd0);
    rd(6'h0C, v); check("R2 rx count", v, 32'd5);
    rd(6'h14, v); check("R2 rx flag", v, 32'd2);
    check("R2 irq", {31'd0, irq}, 32'd1);
    check("R4 rx_ready low", {31'd0, rx_ready}, 32'd0);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h55; rx_last = 1'b1;
    repeat (3) @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    rd(6'h0C, v); check("R4 stream ignored while pending", v, 32'd5);
    wr(6'h14, 32'd1);
    rd(6'h14, v); check("R7 zero bit leaves rx flag", v, 32'd2);
    for (int i = 0; i < 5; i++) begin
      rd(6'h1C, v); check("R3 rx byte", v, 32'hA0 + 32'(i));
      rd(6'h0C, v); check("R3 rx count after read", v, 32'd4 - 32'(i));
    end
    rd(6'h1C, v); check("R3 empty read", v, 32'd0);
    rd(6'h0C, v); check("R3 empty count", v, 32'd0);
    wr(6'h14, 32'd2);
    rd(6'h14, v); check("R7 rx flag cleared", v, 32'd0);
    check("R9 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_tx();
    logic [31:0] v;
    logic [7:0] exp [0:3];
    exp[0] = 8'h11; exp[1] = 8'h22; exp[2] = 8'h33; exp[3] = 8'h44;
    ncap = 0;
    wr(6'h10, 32'd4);
    rd(6'h08, v); check("R10 busy with tx length", v, 32'd1);
    for (int i = 0; i < 4; i++) wr(6'h20, {24'hABCDEE, exp[i]});
    wr(6'h20, 32'h99); wr(6'h20, 32'h98);
    @(negedge clk); tx_ready = 1'b1;
    repeat (8) @(negedge clk);
    tx_ready = 1'b0;
    check("R5 tx byte count", 32'(ncap), 32'd4);
    for (int i = 0; i < 4; i++) begin
      check("R5 tx byte value", {24'd0, cap[i]}, {24'd0, exp[i]});
      check("R5 tx last flag", {31'd0, cap_last[i]}, {31'd0, i == 3});
    end
    rd(6'h10, v); check("R6 tx count cleared", v, 32'd0);
    rd(6'h14, v); check("R6 tx done flag", v, 32'd1);
    check("R9 irq from tx done", {31'd0, irq}, 32'd1);
    wr(6'h14, 32'd1);
    check("R7 tx done cleared irq", {31'd0, irq}, 32'd0);
    wr(6'h10, 32'd1000);
    rd(6'h10, v); check("R11 tx length clamped", v, 32'd256);
  endtask

  task automatic t_test();
    logic [31:0] v;
    wr(6'h14, 32'h8000_0000);
    check("R8 test irq raised", {31'd0, irq}, 32'd1);
    rd(6'h14, v); check("R8 test bit first read", v, 32'h8000_0000);
    rd(6'h14, v); check("R8 test bit second read", v, 32'd0);
    check("R8 irq stays after read", {31'd0, irq}, 32'd1);
    wr(6'h14, 32'd1);
    check("R8 nonzero write keeps irq", {31'd0, irq}, 32'd1);
    wr(6'h14, 32'd0);
    check("R8 zero write clears irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_oversize();
    logic [31:0] v;
    for (int i = 0; i < DEPTH + 4; i++) rx_byte(8'(i), i == DEPTH + 3);
    rd(6'h0C, v); check("R11 rx count truncated", v, 32'd256);
    rd(6'h1C, v); check("R11 first byte kept", v, 32'd0);
    rd(6'h1C, v); check("R11 second byte kept", v, 32'd1);
    rd(6'h0C, v); check("R11 count after reads", v, 32'd254);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx();
    t_tx();
    t_test();
    t_oversize();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule